// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. It drives the clock enable, the on-die-termination enable, the four command strobes, the row/column address and the bank address through the whole power-up bring-up of the memory. Once that work is finished it raises a done flag so that normal traffic can take over the pins. It does not drive the data path, and it does not schedule refreshes after bring-up.

A single-cycle `start` pulse begins the run. First comes a long stretch with the clock enable low and only no-operation commands. Then the clock enable goes high and stays high, and a short settling wait follows. After that the block issues a fixed series of precharge-all, mode-register and extended-mode-register writes, with a group of refreshes in the middle. Every wait is a parameter counted in clock cycles. The operating values for the mode register and the extended mode register come in on ports. The block forces the DLL-reset, DLL-enable and output-driver-calibration bits itself at each step.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, and until `start` is seen, `cke`=0 and `done`=0. The command is NOP, `addr`=0 and `ba`=0.
- R2: `odt` stays 0 at all times.
- R3: After `start`, `cke` stays low with NOP for `T_PWR` cycles. It then goes high and stays high. NOP follows for `T_CKE` cycles, then the first PRECHARGE ALL is issued with A10=1 and BA=000.
- R4: The command bits {cs_n,ras_n,cas_n,we_n} use these encodings: NOP=0111, PRECHARGE=0010, REFRESH=0001, LOAD MODE=0000.
- R5: The writes after the first precharge come in this order:
  - a LOAD MODE to BA=010 with A7=`emr2_a7` and all other address bits 0;
  - then a LOAD MODE to BA=011 with all address bits 0.
- R6: The next write is a LOAD MODE to BA=001 that enables the DLL. It carries `emr_cfg` with A0, A7, A8 and A9 cleared.
- R7: The next write is a LOAD MODE to BA=000 that resets the DLL. It carries `mr_cfg` with A8 set.
- R8: After the DLL reset, the block issues a PRECHARGE ALL (A10=1), then `N_REF` REFRESH commands, then a LOAD MODE to BA=000 carrying `mr_cfg` with A8 cleared.
- R9: Two last writes go to BA=001, both carrying `emr_cfg` with A0 cleared. The first has A9:A7=111 (calibration default). The second has A9:A7=000 (calibration exit).
- R10: The next command starts a fixed number of cycles after the one before it: `T_MRD` after a LOAD MODE, `T_RP` after a PRECHARGE, `T_RFC` after a REFRESH. Only NOP appears in between.
- R11: `done` rises in cycle max(L + `T_MRD`, D + `T_DLL`). Here L is the cycle of the calibration-exit write and D is the cycle of the DLL-reset write. After that `done` stays high, with `cke` high and NOP.
- R12: A `start` pulse received while the sequence runs, or after `done`, has no effect on the command stream or on `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins the sequence when the block is idle |
| mr_cfg | input | ADDR_W | Operating value for the mode register |
| emr_cfg | input | ADDR_W | Operating value for the extended mode register |
| emr2_a7 | input | 1 | Value written to A7 of extended register 2 |
| cke | output | 1 | Clock enable to the memory |
| odt | output | 1 | On-die termination enable (held low) |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | 3 | Bank address |
| done | output | 1 | Initialization complete |

## Verification
The assertions assume that every timing parameter is at least 1. They also assume that `rst_n` is held low for at least one clock edge before the first `start`. The bench meets both: it uses small nonzero counts and holds reset for several cycles before starting. The assertions further assume that the configuration ports stay steady while the sequence runs, because the address checks on each write compare against the port values. The bench sets `mr_cfg`, `emr_cfg` and `emr2_a7` once, before reset is released, and never changes them. It does pulse `start` mid-run and after completion, on purpose, to exercise the ignore rule.

// File: rtl/ddr2_init_pkg.sv
// Package: shared command encodings and sequence step type for the
// DDR2 power-up sequencer. Assumes a 3-bit bank address.
package ddr2_init_pkg;

    localparam int BA_W = 3;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_LMR = 4'b0000;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PWR,
        S_CKE,
        S_PRE1,
        S_EMR2,
        S_EMR3,
        S_EMR1,
        S_MR_RST,
        S_PRE2,
        S_REF,
        S_MR_OP,
        S_OCD_DEF,
        S_OCD_EXIT,
        S_DONE_WAIT,
        S_DONE
    } step_t;

    // True for steps that put a real command on the bus once their gap expires.
    function automatic logic is_cmd_step(step_t s);
        return (s inside {S_PRE1, S_EMR2, S_EMR3, S_EMR1, S_MR_RST, S_PRE2,
                          S_REF, S_MR_OP, S_OCD_DEF, S_OCD_EXIT});
    endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
// Down counter used for every wait in the sequence.
// Assumes: load takes priority; the counter parks at zero.
module ddr2_init_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    // Load a new interval or count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/ddr2_init_dll_wait.sv
// Tracks the DLL lock window that starts at the DLL-reset write.
// Assumes arm is pulsed once per run; expired holds until reset.
module ddr2_init_dll_wait #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic [W-1:0] window_m1,
    output logic         expired
);
    logic         armed;
    logic [W-1:0] cnt;

    // Start the lock window on arm, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            cnt   <= window_m1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = armed && (cnt == '0);
endmodule

// File: rtl/ddr2_init_cmd_enc.sv
// Turns the current step into command, bank and address pin values.
// Assumes ADDR_W >= 11 so that A10 exists. Outputs NOP/zero unless issue is set.
module ddr2_init_cmd_enc
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  step_t             step,
    input  logic              issue,
    input  logic [ADDR_W-1:0] mr_cfg,
    input  logic [ADDR_W-1:0] emr_cfg,
    input  logic              emr2_a7,
    output logic [3:0]        cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] BIT_A0   = ADDR_W'(1) << 0;
    localparam logic [ADDR_W-1:0] BIT_A7   = ADDR_W'(1) << 7;
    localparam logic [ADDR_W-1:0] BIT_A8   = ADDR_W'(1) << 8;
    localparam logic [ADDR_W-1:0] BIT_A10  = ADDR_W'(1) << 10;
    localparam logic [ADDR_W-1:0] OCD_BITS = ADDR_W'(7) << 7;
    localparam logic [ADDR_W-1:0] EMR_CLR  = OCD_BITS | BIT_A0;

    logic [ADDR_W-1:0] emr_base;
    assign emr_base = emr_cfg & ~EMR_CLR;

    // Decode the step into the pin values of its command.
    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        if (issue) begin
            unique case (step)
                S_PRE1, S_PRE2: begin
                    cmd  = CMD_PRE;
                    addr = BIT_A10;
                end
                S_EMR2: begin
                    cmd  = CMD_LMR;
                    ba   = 3'b010;
                    addr = emr2_a7 ? BIT_A7 : '0;
                end
                S_EMR3: begin
                    cmd  = CMD_LMR;
                    ba   = 3'b011;
                end
                S_EMR1: begin
                    cmd  = CMD_LMR;
                    ba   = 3'b001;
                    addr = emr_base;
                end
                S_MR_RST: begin
                    cmd  = CMD_LMR;
                    addr = mr_cfg | BIT_A8;
                end
                S_REF: cmd = CMD_REF;
                S_MR_OP: begin
                    cmd  = CMD_LMR;
                    addr = mr_cfg & ~BIT_A8;
                end
                S_OCD_DEF: begin
                    cmd  = CMD_LMR;
                    ba   = 3'b001;
                    addr = emr_base | OCD_BITS;
                end
                S_OCD_EXIT: begin
                    cmd  = CMD_LMR;
                    ba   = 3'b001;
                    addr = emr_base;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 power-up initialization sequencer (top).
// Walks the memory from power-up to ready: a long NOP stretch with CKE low,
// a settle wait with CKE high, then a fixed ordered list of precharge,
// mode-register and refresh commands, each followed by its gap.
// Assumes all timing parameters are >= 1 and N_REF >= 2; configuration
// inputs are steady during a run. Start is honoured only while idle.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int T_PWR  = 80000,
    parameter int T_CKE  = 160,
    parameter int T_RP   = 6,
    parameter int T_MRD  = 2,
    parameter int T_RFC  = 52,
    parameter int N_REF  = 2,
    parameter int T_DLL  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] mr_cfg,
    input  logic [ADDR_W-1:0] emr_cfg,
    input  logic              emr2_a7,
    output logic              cke,
    output logic              odt,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        ba,
    output logic              done
);
    localparam int MAX_A = (T_PWR > T_CKE) ? T_PWR : T_CKE;
    localparam int MAX_B = (T_RP  > T_MRD) ? T_RP  : T_MRD;
    localparam int MAX_C = (T_RFC > T_DLL) ? T_RFC : T_DLL;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T = (MAX_C > MAX_D) ? MAX_C : MAX_D;
    localparam int TW    = $clog2(MAX_T + 1);
    localparam int RW    = $clog2(N_REF + 1);

    localparam logic [TW-1:0] PWR_M1 = TW'(T_PWR - 1);
    localparam logic [TW-1:0] CKE_M1 = TW'(T_CKE - 1);
    localparam logic [TW-1:0] RP_M1  = TW'(T_RP  - 1);
    localparam logic [TW-1:0] MRD_M1 = TW'(T_MRD - 1);
    localparam logic [TW-1:0] RFC_M1 = TW'(T_RFC - 1);
    localparam logic [TW-1:0] DLL_M1 = TW'(T_DLL - 1);
    localparam logic [RW-1:0] REF_LAST = RW'(N_REF - 1);

    step_t          step;
    logic [RW-1:0]  ref_cnt;
    logic           t_zero;
    logic           t_load;
    logic [TW-1:0]  t_val;
    logic [TW-1:0]  gap_m1;
    logic           issue;
    logic           dll_exp;
    logic [3:0]     cmd;

    assign issue = t_zero && is_cmd_step(step);

    // Pick the gap that follows the command of the current step.
    always_comb begin
        unique case (step)
            S_PRE1, S_PRE2: gap_m1 = RP_M1;
            S_REF:          gap_m1 = RFC_M1;
            default:        gap_m1 = MRD_M1;
        endcase
    end

    // Decide when and with what the shared wait timer is loaded.
    always_comb begin
        t_load = 1'b0;
        t_val  = gap_m1;
        if (step == S_IDLE && start) begin
            t_load = 1'b1;
            t_val  = PWR_M1;
        end else if (step == S_PWR && t_zero) begin
            t_load = 1'b1;
            t_val  = CKE_M1;
        end else if (issue) begin
            t_load = 1'b1;
        end
    end

    // Advance through the ordered list of initialization steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step    <= S_IDLE;
            ref_cnt <= '0;
        end else begin
            unique case (step)
                S_IDLE:      if (start)  step <= S_PWR;
                S_PWR:       if (t_zero) step <= S_CKE;
                S_CKE:       if (t_zero) step <= S_PRE1;
                S_PRE1:      if (t_zero) step <= S_EMR2;
                S_EMR2:      if (t_zero) step <= S_EMR3;
                S_EMR3:      if (t_zero) step <= S_EMR1;
                S_EMR1:      if (t_zero) step <= S_MR_RST;
                S_MR_RST:    if (t_zero) step <= S_PRE2;
                S_PRE2:      if (t_zero) step <= S_REF;
                S_REF: begin
                    if (t_zero) begin
                        if (ref_cnt == REF_LAST) begin
                            ref_cnt <= '0;
                            step    <= S_MR_OP;
                        end else begin
                            ref_cnt <= ref_cnt + 1'b1;
                        end
                    end
                end
                S_MR_OP:     if (t_zero) step <= S_OCD_DEF;
                S_OCD_DEF:   if (t_zero) step <= S_OCD_EXIT;
                S_OCD_EXIT:  if (t_zero) step <= S_DONE_WAIT;
                S_DONE_WAIT: if (t_zero && dll_exp) step <= S_DONE;
                S_DONE:      step <= S_DONE;
                default:     step <= S_IDLE;
            endcase
        end
    end

    ddr2_init_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    ddr2_init_dll_wait #(.W(TW)) u_dll (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (issue && step == S_MR_RST),
        .window_m1 (DLL_M1),
        .expired   (dll_exp)
    );

    ddr2_init_cmd_enc #(.ADDR_W(ADDR_W)) u_enc (
        .step    (step),
        .issue   (issue),
        .mr_cfg  (mr_cfg),
        .emr_cfg (emr_cfg),
        .emr2_a7 (emr2_a7),
        .cmd     (cmd),
        .ba      (ba),
        .addr    (addr)
    );

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign cke  = !(step == S_IDLE || step == S_PWR);
    assign odt  = 1'b0;
    assign done = (step == S_DONE) || (step == S_DONE_WAIT && t_zero && dll_exp);
endmodule

// File: rtl/ddr2_init_seq_chk.sv
// Checker for the DDR2 initialization sequencer, watching only its ports.
// Assumes the configuration inputs are steady during a run.
module ddr2_init_seq_chk #(
    parameter int ADDR_W = 14,
    parameter int T_MRD  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [2:0]        ba,
    input logic [ADDR_W-1:0] mr_cfg,
    input logic [ADDR_W-1:0] emr_cfg,
    input logic              emr2_a7,
    input logic              done
);
    logic [3:0] cmd;
    logic       lmr;
    assign cmd = {cs_n, ras_n, cas_n, we_n};
    assign lmr = (cmd == 4'b0000);

    AST_NOP_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> cmd == 4'b0111);                                             // R3
    AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);                                                         // R3
    AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd inside {4'b0111, 4'b0010, 4'b0001, 4'b0000});                     // R4
    AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 4'b0010 |-> addr[10] && ba == 3'b000);                         // R8
    AST_EMR2_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        lmr && ba == 3'b010 |-> addr == (ADDR_W'(emr2_a7) << 7));             // R5
    AST_EMR3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lmr && ba == 3'b011 |-> addr == '0);                                  // R5
    AST_EMR_A0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        lmr && ba == 3'b001 |-> !addr[0] && addr[6:1] == emr_cfg[6:1]);       // R9
    AST_MR_LOW_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        lmr && ba == 3'b000 |-> addr[7:0] == mr_cfg[7:0]);                    // R7
    AST_LMR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (T_MRD > 1) && lmr |=> cmd == 4'b0111);                               // R10
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);                                                       // R11
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cke && cmd == 4'b0111);                                      // R11
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ADDR_W(ADDR_W), .T_MRD(T_MRD)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .addr    (addr),
    .ba      (ba),
    .mr_cfg  (mr_cfg),
    .emr_cfg (emr_cfg),
    .emr2_a7 (emr2_a7),
    .done    (done)
);

// File: tb/ddr2_init_seq_test.sv
`timescale 1ns/1ps
// Bench: walks the expected command table cycle by cycle, then directed
// tests for reset, the done timing and ignored start pulses.
module ddr2_init_seq_test;
    localparam int T_PWR = 20;
    localparam int T_CKE = 5;
    localparam int T_RP  = 3;
    localparam int T_MRD = 2;
    localparam int T_RFC = 6;
    localparam int N_REF = 3;
    localparam int T_DLL = 40;
    localparam int T_DLL_FAST = 4;

    localparam logic [13:0] MR_CFG  = 14'h0963;
    localparam logic [13:0] EMR_CFG = 14'h03C5;

    // {cmd[3:0], ba[2:0], addr[13:0], gap[7:0]}
    localparam logic [28:0] VEC [0:11] = '{
        {4'b0010, 3'b000, 14'h0400, 8'(T_RP)},   // R3 first precharge all
        {4'b0000, 3'b010, 14'h0080, 8'(T_MRD)},  // R5 ext reg 2
        {4'b0000, 3'b011, 14'h0000, 8'(T_MRD)},  // R5 ext reg 3
        {4'b0000, 3'b001, 14'h0044, 8'(T_MRD)},  // R6 DLL enable
        {4'b0000, 3'b000, 14'h0963, 8'(T_MRD)},  // R7 DLL reset
        {4'b0010, 3'b000, 14'h0400, 8'(T_RP)},   // R8 precharge all
        {4'b0001, 3'b000, 14'h0000, 8'(T_RFC)},  // R8 refresh 1
        {4'b0001, 3'b000, 14'h0000, 8'(T_RFC)},  // R8 refresh 2
        {4'b0001, 3'b000, 14'h0000, 8'(T_RFC)},  // R8 refresh 3
        {4'b0000, 3'b000, 14'h0863, 8'(T_MRD)},  // R8 operating MR
        {4'b0000, 3'b001, 14'h03C4, 8'(T_MRD)},  // R9 calibration default
        {4'b0000, 3'b001, 14'h0044, 8'(T_MRD)}   // R9 calibration exit
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [13:0] mr_cfg;
    logic [13:0] emr_cfg;
    logic        emr2_a7;
    logic        cke, odt, cs_n, ras_n, cas_n, we_n, done;
    logic [13:0] addr;
    logic [2:0]  ba;
    logic        f_cke, f_odt, f_cs_n, f_ras_n, f_cas_n, f_we_n, f_done;
    logic [13:0] f_addr;
    logic [2:0]  f_ba;

    int nvec  = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    ddr2_init_seq #(.ADDR_W(14), .T_PWR(T_PWR), .T_CKE(T_CKE), .T_RP(T_RP),
        .T_MRD(T_MRD), .T_RFC(T_RFC), .N_REF(N_REF), .T_DLL(T_DLL)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mr_cfg(mr_cfg),
        .emr_cfg(emr_cfg), .emr2_a7(emr2_a7), .cke(cke), .odt(odt),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .done(done));

    ddr2_init_seq #(.ADDR_W(14), .T_PWR(T_PWR), .T_CKE(T_CKE), .T_RP(T_RP),
        .T_MRD(T_MRD), .T_RFC(T_RFC), .N_REF(N_REF), .T_DLL(T_DLL_FAST)) uut_fast (
        .clk(clk), .rst_n(rst_n), .start(start), .mr_cfg(mr_cfg),
        .emr_cfg(emr_cfg), .emr2_a7(emr2_a7), .cke(f_cke), .odt(f_odt),
        .cs_n(f_cs_n), .ras_n(f_ras_n), .cas_n(f_cas_n), .we_n(f_we_n),
        .addr(f_addr), .ba(f_ba), .done(f_done));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int i);
        case (i)
            0:             return "R3";
            1, 2:          return "R5";
            3:             return "R6";
            4:             return "R7";
            5, 6, 7, 8, 9: return "R8";
            default:       return "R9";
        endcase
    endfunction

    function automatic logic is_nop();
        return {cs_n, ras_n, cas_n, we_n} == 4'b0111;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int bad;
        rst_n   = 1'b0;
        start   = 1'b0;
        mr_cfg  = MR_CFG;
        emr_cfg = EMR_CFG;
        emr2_a7 = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!cke && !done && is_nop() && addr == 0 && ba == 0, "R1", "reset state",
            {cke, done, cs_n, ras_n, cas_n, we_n}, 32'h07);
        chk(odt == 1'b0, "R2", "odt in reset", odt, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!cke && !done && is_nop(), "R1", "idle without start",
            {cke, done, cs_n, ras_n, cas_n, we_n}, 32'h07);

        // launch
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bad = 0;
        for (int n = 1; n <= T_PWR; n++) begin
            if (cke || !is_nop() || odt) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R3", "cke low NOP window", bad, 0);
        bad = 0;
        for (int n = 1; n <= T_CKE; n++) begin
            if (!cke || !is_nop() || odt) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R3", "cke high settle window", bad, 0);

        // table walk; start pulses mid-run to exercise R12
        for (int i = 0; i < 12; i++) begin
            chk({cs_n, ras_n, cas_n, we_n, ba, addr} == VEC[i][28:8] && cke && !odt,
                req_of(i), $sformatf("command %0d", i),
                {cs_n, ras_n, cas_n, we_n, ba, addr}, VEC[i][28:8]);
            if (i == 7) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            bad = 0;
            for (int g = 1; g < int'(VEC[i][7:0]); g++) begin
                if (!is_nop() || done || f_done || !cke || odt) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R10", $sformatf("gap after command %0d", i), bad, 0);
        end

        // R11: fast instance bound by the final gap, main one by the DLL window
        chk(f_done == 1'b1, "R11", "done after final gap", f_done, 1);
        bad = 0;
        for (int k = 38; k < 49; k++) begin
            if (done || !is_nop() || !cke) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R11", "done held off by DLL window", bad, 0);
        chk(done == 1'b1 && cke && is_nop(), "R11", "done at DLL window end", done, 1);

        // R12: start after done has no effect
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            if (!done || !cke || !is_nop() || odt) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R12", "start after done ignored", bad, 0);

        // R1: reset returns to idle
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cke && !done && is_nop() && !odt, "R1", "idle after re-reset",
            {cke, done, cs_n, ras_n, cas_n, we_n}, 32'h07);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule